// File: doc/BRIEF.md
# Four-Mode Timer/Counter with Capture

This block is a pair of 8-bit counting halves. A 2-bit mode field decides how the pair is used. The choices are two separate 8-bit timers, an 8-bit timer beside an 8-bit event counter, a single 16-bit timer, or a single 16-bit event counter. Timer counting is paced by an 8-bit programmable prescaler, which advances on a per-cycle-time clock enable. Event counting follows rising edges of an asynchronous input, which passes through a synchroniser first.

Each half carries a match value. When a half sits at its match value and is told to count again, it returns to zero and raises its match flag. In the 16-bit modes the two halves act as one counter, and only the high flag is used. Two capture strobes, one for each half, copy the running count into a capture register. In the 16-bit modes either strobe takes all 16 bits.

A plain write-strobe interface loads the mode and prescaler setting together, loads the 16-bit match value, and clears flags. Clearing is write-one-to-clear. The count and capture values are visible at all times.

Top module: `capture_timer`

## Requirements
- R1: After synchronous reset, count, capture, flag_lo and flag_hi are all zero, the mode is 0, the prescaler setting is 0 and the match value is 16'hFFFF.
- R2: In timer operation the counter advances once for every PRESC+1 cycles in which tick_en is high, where PRESC is the programmed prescaler value. Cycles with tick_en low do not advance it.
- R3: In mode 0 (cfg_mode = 2'd0) the low half is count[7:0] and the high half is count[15:8]. Both halves count prescaler ticks on their own, against match_val[7:0] and match_val[15:8] respectively. A half at its match value goes to zero on its next count and sets its flag (flag_lo or flag_hi).
- R4: In mode 1 (2'd1) count[7:0] counts prescaler ticks and count[15:8] counts event edges. In mode 0, event edges have no effect on the count.
- R5: evt_in passes through a two-flop synchroniser. Each rising edge adds exactly one count, however long the input stays high.
- R6: In mode 2 (2'd2) count[15:0] is one prescaled 16-bit timer, and the low byte carries into the high byte. On a full 16-bit match it goes to zero and sets flag_hi only. flag_lo is never set in modes 2 and 3.
- R7: In mode 3 (2'd3) count[15:0] is one 16-bit counter of event edges. tick_en has no effect on it. It wraps and sets flag_hi on a full match.
- R8: In modes 0 and 1, cap_lo_stb copies count[7:0] into capture[7:0] and cap_hi_stb copies count[15:8] into capture[15:8]. Each strobe leaves the other byte untouched. In modes 2 and 3, either strobe copies all 16 bits.
- R9: A flag stays set until a cycle with flag_clr_we high and a one in its bit of flag_clr. Bit 0 is the low flag and bit 1 is the high flag. A zero bit leaves that flag unchanged.
- R10: A cfg_we write loads the mode and prescaler setting and returns the count and the prescaler to zero. Flags and capture values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per instruction cycle time, feeds the prescaler |
| evt_in | input | 1 | Asynchronous external event input |
| cap_lo_stb | input | 1 | Capture strobe for the low half |
| cap_hi_stb | input | 1 | Capture strobe for the high half |
| cfg_we | input | 1 | Write strobe for mode and prescaler setting |
| cfg_mode | input | 2 | Mode value to load |
| cfg_presc | input | 8 | Prescaler setting to load (divide by value+1) |
| match_we | input | 1 | Write strobe for the match value |
| match_val | input | 16 | Match value, high byte for the high half |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Flags to clear, bit 0 low, bit 1 high |
| count | output | 16 | Current count of both halves |
| capture | output | 16 | Captured value, high byte from the high half |
| flag_lo | output | 1 | Low-half match flag |
| flag_hi | output | 1 | High-half (or 16-bit) match flag |

## Verification
The counting path is driven three ways: with a continuous enable and a divide setting of four, with the enable held off, and with the enable toggled every other cycle. Together these show that the divider counts enable cycles and not clock cycles. Match values are chosen differently for the two halves, so that mode 0 shows independent wraps and flags. In mode 2 the same low byte carries instead of wrapping, which exposes any mixing up of the 8-bit and 16-bit paths. Event pulses of one cycle and of many cycles, applied in modes 0, 1 and 3, separate edge counting from level counting and show which half, if any, takes events. Captures with the counter stopped, first of one half and then the other, show that the byte lanes are separate in 8-bit modes and joined in 16-bit modes.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8  = 2'd0,
    MODE_T8_EV8 = 2'd1,
    MODE_T16    = 2'd2,
    MODE_EV16   = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick_en,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic             at_end;

  assign at_end = (pcnt_q == reload);
  assign tick   = tick_en && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt_q <= '0;
    end else if (tick_en) begin
      if (at_end) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      seen_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] && !seen_q;
endmodule

// File: rtl/cap_count_core.sv
module cap_count_core
  import cap_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  tmr_mode_e         mode,
  input  logic              pre_tick,
  input  logic              evt_tick,
  input  logic [FULL_W-1:0] match,
  input  logic              flag_clr_we,
  input  logic [1:0]        flag_clr,
  output logic [FULL_W-1:0] count,
  output logic              flag_lo,
  output logic              flag_hi
);
  logic              wide;
  logic              wide_step;
  logic [1:0]        half_step;
  logic [HALF_W-1:0] half_nxt [2];
  logic [1:0]        half_set;
  logic [FULL_W-1:0] count_n;
  logic [1:0]        set_n;
  logic [1:0]        flag_q;

  assign wide         = (mode == MODE_T16) || (mode == MODE_EV16);
  assign wide_step    = (mode == MODE_T16) ? pre_tick : evt_tick;
  assign half_step[0] = pre_tick;
  assign half_step[1] = (mode == MODE_T8_EV8) ? evt_tick : pre_tick;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] cur;
    logic [HALF_W-1:0] lim;
    assign cur = count[h*HALF_W +: HALF_W];
    assign lim = match[h*HALF_W +: HALF_W];
    always_comb begin
      half_nxt[h] = cur;
      half_set[h] = 1'b0;
      if (half_step[h]) begin
        if (cur == lim) begin
          half_nxt[h] = '0;
          half_set[h] = 1'b1;
        end else begin
          half_nxt[h] = cur + 1'b1;
        end
      end
    end
  end

  always_comb begin
    count_n = count;
    set_n   = 2'b00;
    if (clear) begin
      count_n = '0;
    end else if (wide) begin
      if (wide_step) begin
        if (count == match) begin
          count_n  = '0;
          set_n[1] = 1'b1;
        end else begin
          count_n = count + 1'b1;
        end
      end
    end else begin
      count_n = {half_nxt[1], half_nxt[0]};
      set_n   = half_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_n;
  end

  for (genvar f = 0; f < 2; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[f] <= 1'b0;
      else     flag_q[f] <= set_n[f] | (flag_q[f] & ~(flag_clr_we & flag_clr[f]));
    end
  end

  assign flag_lo = flag_q[0];
  assign flag_hi = flag_q[1];
endmodule

// File: rtl/cap_capture.sv
module cap_capture #(
  parameter int HALF_W = 8,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              stb_lo,
  input  logic              stb_hi,
  input  logic [FULL_W-1:0] count,
  output logic [FULL_W-1:0] capture
);
  logic [1:0] take;

  assign take[0] = wide ? (stb_lo | stb_hi) : stb_lo;
  assign take[1] = wide ? (stb_lo | stb_hi) : stb_hi;

  for (genvar h = 0; h < 2; h++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          capture[h*HALF_W +: HALF_W] <= '0;
      else if (take[h]) capture[h*HALF_W +: HALF_W] <= count[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import cap_timer_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              evt_in,
  input  logic              cap_lo_stb,
  input  logic              cap_hi_stb,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [PRE_W-1:0]  cfg_presc,
  input  logic              match_we,
  input  logic [FULL_W-1:0] match_val,
  input  logic              flag_clr_we,
  input  logic [1:0]        flag_clr,
  output logic [FULL_W-1:0] count,
  output logic [FULL_W-1:0] capture,
  output logic              flag_lo,
  output logic              flag_hi
);
  tmr_mode_e         mode_q;
  logic [PRE_W-1:0]  presc_q;
  logic [FULL_W-1:0] match_q;
  logic              pre_tick;
  logic              evt_tick;
  logic              wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_DUAL8;
      presc_q <= '0;
      match_q <= '1;
    end else begin
      if (cfg_we) begin
        mode_q  <= tmr_mode_e'(cfg_mode);
        presc_q <= cfg_presc;
      end
      if (match_we) match_q <= match_val;
    end
  end

  assign wide = mode_q[1];

  cap_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_we),
    .tick_en (tick_en),
    .reload  (presc_q),
    .tick    (pre_tick)
  );

  cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (evt_in),
    .rise     (evt_tick)
  );

  cap_count_core #(.HALF_W(HALF_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .clear       (cfg_we),
    .mode        (mode_q),
    .pre_tick    (pre_tick),
    .evt_tick    (evt_tick),
    .match       (match_q),
    .flag_clr_we (flag_clr_we),
    .flag_clr    (flag_clr),
    .count       (count),
    .flag_lo     (flag_lo),
    .flag_hi     (flag_hi)
  );

  cap_capture #(.HALF_W(HALF_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .wide    (wide),
    .stb_lo  (cap_lo_stb),
    .stb_hi  (cap_hi_stb),
    .count   (count),
    .capture (capture)
  );
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         cfg_we,
  input logic         flag_clr_we,
  input logic [1:0]   flag_clr,
  input logic [1:0]   mode_q,
  input logic         evt_tick,
  input logic [W-1:0] count,
  input logic         flag_lo,
  input logic         flag_hi
);
  // R10
  cfg_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (count == '0));

  // R2
  idle_holds_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cfg_we && (mode_q == 2'd0 || mode_q == 2'd2)) |=> $stable(count));

  // R7
  ev16_waits_event_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd3 && !evt_tick && !cfg_we) |=> $stable(count));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt_tick |=> !evt_tick);

  // R6
  wide_no_lo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[1] |=> !$rose(flag_lo));

  // R9
  lo_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_lo && !(flag_clr_we && flag_clr[0])) |=> flag_lo);

  // R9
  hi_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && !(flag_clr_we && flag_clr[1])) |=> flag_hi);
endmodule

bind capture_timer cap_timer_chk #(.W(FULL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .cfg_we      (cfg_we),
  .flag_clr_we (flag_clr_we),
  .flag_clr    (flag_clr),
  .mode_q      (mode_q),
  .evt_tick    (evt_tick),
  .count       (count),
  .flag_lo     (flag_lo),
  .flag_hi     (flag_hi)
);

// File: tb/capture_timer_tb.sv
module capture_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        evt_in = 1'b0;
  logic        cap_lo_stb = 1'b0;
  logic        cap_hi_stb = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [7:0]  cfg_presc = 8'd0;
  logic        match_we = 1'b0;
  logic [15:0] match_val = 16'd0;
  logic        flag_clr_we = 1'b0;
  logic [1:0]  flag_clr = 2'b00;
  logic [15:0] count;
  logic [15:0] capture;
  logic        flag_lo;
  logic        flag_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  capture_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .evt_in(evt_in),
    .cap_lo_stb(cap_lo_stb), .cap_hi_stb(cap_hi_stb),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_presc(cfg_presc),
    .match_we(match_we), .match_val(match_val),
    .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
    .count(count), .capture(capture), .flag_lo(flag_lo), .flag_hi(flag_hi)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [7:0] p);
    cfg_we = 1'b1; cfg_mode = m; cfg_presc = p;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_match(input logic [15:0] v);
    match_we = 1'b1; match_val = v;
    cyc(1);
    match_we = 1'b0;
  endtask

  task automatic clr_flags(input logic [1:0] b);
    flag_clr_we = 1'b1; flag_clr = b;
    cyc(1);
    flag_clr_we = 1'b0; flag_clr = 2'b00;
  endtask

  task automatic run(input int n);
    tick_en = 1'b1;
    cyc(n);
    tick_en = 1'b0;
  endtask

  task automatic pulse_evt(input int hi_len);
    evt_in = 1'b1;
    cyc(hi_len);
    evt_in = 1'b0;
    cyc(4);
  endtask

  task automatic strobe(input bit lo, input bit hi);
    cap_lo_stb = lo; cap_hi_stb = hi;
    cyc(1);
    cap_lo_stb = 1'b0; cap_hi_stb = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "count", count, 16'h0000);
    check("R1", "capture", capture, 16'h0000);
    check("R1", "flags", {14'd0, flag_hi, flag_lo}, 16'h0000);
    run(3);
    check("R1", "match reset all-ones, mode 0 step", count, 16'h0303);
  endtask

  task automatic t_prescale;
    set_match(16'hFFFF);
    set_cfg(2'd0, 8'd3);
    run(20);
    check("R2", "divide by 4 after 20 enables", count, 16'h0505);
    cyc(10);
    check("R2", "enable low holds", count, 16'h0505);
    for (int i = 0; i < 8; i++) begin
      tick_en = 1'b1; cyc(1);
      tick_en = 1'b0; cyc(1);
    end
    check("R2", "sparse enables counted", count, 16'h0707);
  endtask

  task automatic t_dual_match;
    clr_flags(2'b11);
    set_match(16'h0503);
    set_cfg(2'd0, 8'd0);
    run(4);
    check("R3", "low wrap, high running", count, 16'h0400);
    check("R3", "flag_lo set", {15'd0, flag_lo}, 16'd1);
    check("R3", "flag_hi clear", {15'd0, flag_hi}, 16'd0);
    run(2);
    check("R3", "high wrap", count, 16'h0002);
    check("R3", "flag_hi set", {15'd0, flag_hi}, 16'd1);
  endtask

  task automatic t_flag_clear;
    clr_flags(2'b00);
    check("R9", "zero bits keep flags", {14'd0, flag_hi, flag_lo}, 16'h0003);
    clr_flags(2'b01);
    check("R9", "low cleared only", {14'd0, flag_hi, flag_lo}, 16'h0002);
    set_cfg(2'd0, 8'd0);
    check("R10", "cfg write zeroes count", count, 16'h0000);
    check("R10", "cfg write keeps flag_hi", {15'd0, flag_hi}, 16'd1);
    clr_flags(2'b10);
    check("R9", "high cleared", {14'd0, flag_hi, flag_lo}, 16'h0000);
  endtask

  task automatic t_events;
    set_match(16'hFFFF);
    set_cfg(2'd0, 8'd0);
    pulse_evt(2);
    check("R4", "mode 0 ignores events", count, 16'h0000);
    set_cfg(2'd1, 8'd0);
    for (int i = 0; i < 3; i++) pulse_evt(1);
    check("R4", "mode 1 high counts edges", count, 16'h0300);
    pulse_evt(12);
    check("R5", "long high counts once", count, 16'h0400);
    run(5);
    check("R4", "mode 1 low counts ticks", count, 16'h0405);
  endtask

  task automatic t_wide_timer;
    clr_flags(2'b11);
    set_match(16'h0105);
    set_cfg(2'd2, 8'd0);
    run(256);
    check("R6", "carry into high byte", count, 16'h0100);
    run(5);
    check("R6", "at match", count, 16'h0105);
    check("R6", "no flag before wrap", {14'd0, flag_hi, flag_lo}, 16'h0000);
    run(1);
    check("R6", "wrap to zero", count, 16'h0000);
    check("R6", "only flag_hi set", {14'd0, flag_hi, flag_lo}, 16'h0002);
  endtask

  task automatic t_wide_events;
    clr_flags(2'b11);
    set_match(16'h0002);
    set_cfg(2'd3, 8'd0);
    run(30);
    check("R7", "tick_en ignored", count, 16'h0000);
    pulse_evt(1);
    pulse_evt(3);
    check("R7", "two events", count, 16'h0002);
    pulse_evt(1);
    check("R7", "wrap on third", count, 16'h0000);
    check("R7", "flag_hi only", {14'd0, flag_hi, flag_lo}, 16'h0002);
  endtask

  task automatic t_capture;
    set_match(16'hFFFF);
    set_cfg(2'd2, 8'd0);
    run(291);
    strobe(1'b1, 1'b0);
    check("R8", "16-bit capture by low strobe", capture, 16'h0123);
    set_cfg(2'd0, 8'd0);
    check("R10", "capture kept over cfg write", capture, 16'h0123);
    run(7);
    strobe(1'b1, 1'b0);
    check("R8", "low lane only", capture, 16'h0107);
    run(2);
    strobe(1'b0, 1'b1);
    check("R8", "high lane only", capture, 16'h0907);
    set_cfg(2'd3, 8'd0);
    pulse_evt(1);
    strobe(1'b0, 1'b1);
    check("R8", "16-bit capture by high strobe", capture, 16'h0001);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_prescale();
    t_dual_match();
    t_flag_clear();
    t_events();
    t_wide_timer();
    t_wide_events();
    t_capture();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule